// File: doc/BRIEF.md
# Segmented Event Ring Producer

This block acts as the hardware producer of a circular event ring that software drains. The ring is not one contiguous buffer. It is a chain of memory segments, and a small table gives the base address and the record capacity of each segment. For every accepted event request, the block writes one 16-byte record through a simple word-wide write port. Each record carries a 64-bit parameter, a 32-bit length word and a 32-bit flags word. The flags word is always written last because it holds the ownership (cycle) bit.

The enqueue position walks through the segments in table order. Leaving the last valid segment wraps it back to segment 0 and inverts the producer cycle state. Software reports its progress through a dequeue pointer whose low four bits carry a segment hint and a busy flag; these bits play no part in address comparison. When the slot after the current one would collide with the dequeue pointer, the block holds off the pending request. It then writes a single ring-full error record into the last free slot and waits until software moves its dequeue pointer.

Top module: `evring_producer`

## Requirements
- R1: After reset, and while `ringEnable` is low, `enqAddr` equals the segment-0 base, `enqCycle` is 1, `wrValid` is 0 and `evReady` is 0.
- R2: An accepted record is written as four consecutive 32-bit beats to slot address +0, +4, +8, +12, carrying parameter bits 31:0, parameter bits 63:32, the length word, then the flags word (segment bases are 16-byte aligned).
- R3: The flags word holds the completion code in bits 31:24, the 6-bit record type in bits 15:10 and the producer cycle state in bit 0; all other bits are 0.
- R4: `evReady` is high only while no record is being written. The first beat of a record appears in the cycle after the handshake (`evValid` and `evReady` both high at a clock edge).
- R5: `evPosted` is high for exactly the one cycle that follows the flags-word beat.
- R6: After each record, the enqueue position advances by 16 bytes within the current segment, whose capacity in records comes from that segment's table size entry.
- R7: After the last record of a segment, the enqueue position moves to the base of the next table entry.
- R8: After the last record of segment `segCount-1`, the enqueue position returns to segment 0 and `enqCycle` inverts. Nothing else changes `enqCycle` while the ring stays enabled.
- R9: When the slot after the current enqueue slot matches the dequeue pointer, the request is not accepted. Instead, a ring-full record (code 21, type 37, zero parameter and length) is written in the current slot, and the position advances.
- R10: After a ring-full record, no request is accepted until the dequeue pointer address changes. The request that was held is then accepted.
- R11: Dequeue pointer bits 3:0 (segment hint, busy flag) do not affect full detection or stall release.
- R12: Lowering `ringEnable` returns the enqueue position to segment 0, offset 0, with cycle state 1, and clears any stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringEnable | input | 1 | Ring enable; low holds the producer at its start position |
| evValid | input | 1 | Event request present |
| evReady | output | 1 | Event request accepted at this edge when evValid is high |
| evType | input | 6 | Record type |
| evCode | input | 8 | Completion code |
| evParam | input | 64 | 64-bit parameter / buffer field |
| evLen | input | 32 | Length word |
| segBase | input | SEGS x 64 | Per-entry segment base address |
| segSize | input | SEGS x 16 | Per-entry segment capacity in records (at least 1) |
| segCount | input | SEG_IDX_W+1 | Number of valid table entries (1..SEGS) |
| deqPtr | input | 64 | Software dequeue pointer; bits 2:0 hint, bit 3 busy |
| wrValid | output | 1 | Write beat valid |
| wrAddr | output | 64 | Byte address of the write beat |
| wrData | output | 32 | Write beat data |
| enqAddr | output | 64 | Current enqueue slot address |
| enqSeg | output | SEG_IDX_W | Current enqueue segment index |
| enqCycle | output | 1 | Producer cycle state |
| evPosted | output | 1 | One-cycle strobe after a record is complete |

## Verification
A handshake at edge t produces write beats in the four cycles t+1 to t+4, with the flags word at t+4. `evPosted`, the new enqueue position and any cycle inversion all appear together at t+5, and that is also the first cycle in which `evReady` can rise again. Stall release is registered, so a change of dequeue address allows a new handshake one edge later. The bench drives inputs just after the rising edge. On every falling edge, a behavioural model predicts the values due in that cycle and compares them with the DUT. The model then steps using the same inputs that the DUT sees at the next rising edge.

// File: rtl/evring_pkg.sv
package evring_pkg;

  localparam int WORD_W  = 32;
  localparam int PARAM_W = 64;
  localparam int TYPE_W  = 6;
  localparam int CODE_W  = 8;

  localparam logic [CODE_W-1:0] CODE_RING_FULL = 8'd21;
  localparam logic [TYPE_W-1:0] TYPE_CTRL_EVT  = 6'd37;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       loadReq;   // capture the request fields
    logic       loadFull;  // capture a ring-full record and arm the stall
    logic       wrEn;      // a write beat is on the port
    logic [1:0] wordSel;   // which 32-bit word of the record
    logic       advance;   // move the enqueue position by one record
    logic       clearPos;  // return to the start position
  } ctrlStrobes_t;

  function automatic logic [WORD_W-1:0] packFlags(input logic [CODE_W-1:0] code,
                                                  input logic [TYPE_W-1:0] kind,
                                                  input logic cyc);
    return {code, 8'h00, kind, 9'h000, cyc};
  endfunction

endpackage

// File: rtl/evring_ctrl.sv
module evring_ctrl
  import evring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ringEnable,
  input  logic         evValid,
  input  logic         ringFull,
  input  logic         stalled,
  output logic         evReady,
  output logic         evPosted,
  output ctrlStrobes_t ctl
);

  typedef enum logic {S_IDLE, S_WRITE} state_t;

  state_t     state;
  logic [1:0] beat;
  logic       postedQ;
  logic       idle;

  assign idle     = (state == S_IDLE);
  assign evReady  = ringEnable && idle && !stalled && !ringFull;
  assign evPosted = postedQ;

  always_comb begin
    ctl          = '0;
    ctl.loadReq  = evValid && evReady;
    ctl.loadFull = ringEnable && idle && !stalled && ringFull && evValid;
    ctl.wrEn     = ringEnable && !idle;
    ctl.wordSel  = beat;
    ctl.advance  = ringEnable && !idle && (beat == 2'd3);
    ctl.clearPos = !ringEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !ringEnable) begin
      state   <= S_IDLE;
      beat    <= 2'd0;
      postedQ <= 1'b0;
    end else begin
      postedQ <= ctl.advance;
      unique case (state)
        S_IDLE: begin
          if (ctl.loadReq || ctl.loadFull) begin
            state <= S_WRITE;
            beat  <= 2'd0;
          end
        end
        S_WRITE: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evring_datapath.sv
module evring_datapath
  import evring_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int SEGS      = 4,
  parameter int SIZE_W    = 16,
  parameter int SEG_IDX_W = 2
)(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStrobes_t                     ctl,
  input  logic [TYPE_W-1:0]                evType,
  input  logic [CODE_W-1:0]                evCode,
  input  logic [PARAM_W-1:0]               evParam,
  input  logic [WORD_W-1:0]                evLen,
  input  logic [SEGS-1:0][ADDR_W-1:0]      segBase,
  input  logic [SEGS-1:0][SIZE_W-1:0]      segSize,
  input  logic [SEG_IDX_W:0]               segCount,
  input  logic [ADDR_W-1:0]                deqPtr,
  output logic                             ringFull,
  output logic                             stalled,
  output logic                             wrValid,
  output logic [ADDR_W-1:0]                wrAddr,
  output logic [WORD_W-1:0]                wrData,
  output logic [ADDR_W-1:0]                enqAddr,
  output logic [SEG_IDX_W-1:0]             enqSeg,
  output logic                             enqCycle
);

  localparam int CMP_W = ADDR_W - 4;

  // Enqueue position
  logic [SEG_IDX_W-1:0] seg, nxtSeg;
  logic [SIZE_W-1:0]    off, nxtOff;
  logic                 cyc;
  logic                 lastInSeg, lastSeg, wrapRing;
  logic [ADDR_W-1:0]    nxtAddr;

  // Captured record
  logic [PARAM_W-1:0]   recParam;
  logic [WORD_W-1:0]    recLen;
  logic [TYPE_W-1:0]    recType;
  logic [CODE_W-1:0]    recCode;

  // Stall tracking
  logic [CMP_W-1:0]     stallDeq;
  logic [CMP_W-1:0]     deqAddr;
  logic                 unusedDeqLow;

  assign deqAddr      = deqPtr[ADDR_W-1:4];
  assign unusedDeqLow = ^deqPtr[3:0];

  assign lastInSeg = (off == segSize[seg] - SIZE_W'(1));
  assign lastSeg   = ({1'b0, seg} == segCount - (SEG_IDX_W+1)'(1));
  assign wrapRing  = lastInSeg && lastSeg;

  always_comb begin
    nxtSeg = seg;
    nxtOff = off + SIZE_W'(1);
    if (lastInSeg) begin
      nxtOff = '0;
      nxtSeg = lastSeg ? '0 : seg + SEG_IDX_W'(1);
    end
  end

  assign enqAddr  = segBase[seg] + ADDR_W'({off, 4'b0000});
  assign nxtAddr  = segBase[nxtSeg] + ADDR_W'({nxtOff, 4'b0000});
  assign ringFull = (nxtAddr[ADDR_W-1:4] == deqAddr);
  assign enqSeg   = seg;
  assign enqCycle = cyc;

  // Record word select
  logic [3:0][WORD_W-1:0] recWords;
  assign recWords[0] = recParam[WORD_W-1:0];
  assign recWords[1] = recParam[PARAM_W-1:WORD_W];
  assign recWords[2] = recLen;
  assign recWords[3] = packFlags(recCode, recType, cyc);

  assign wrValid = ctl.wrEn;
  assign wrData  = recWords[ctl.wordSel];
  assign wrAddr  = enqAddr + ADDR_W'({ctl.wordSel, 2'b00});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seg      <= '0;
      off      <= '0;
      cyc      <= 1'b1;
      stalled  <= 1'b0;
      stallDeq <= '0;
    end else if (ctl.clearPos) begin
      seg      <= '0;
      off      <= '0;
      cyc      <= 1'b1;
      stalled  <= 1'b0;
    end else begin
      if (ctl.advance) begin
        seg <= nxtSeg;
        off <= nxtOff;
        if (wrapRing) cyc <= ~cyc;
      end
      if (ctl.loadFull) begin
        stalled  <= 1'b1;
        stallDeq <= deqAddr;
      end else if (stalled && (deqAddr != stallDeq)) begin
        stalled <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recParam <= '0;
      recLen   <= '0;
      recType  <= '0;
      recCode  <= '0;
    end else if (ctl.loadFull) begin
      recParam <= '0;
      recLen   <= '0;
      recType  <= TYPE_CTRL_EVT;
      recCode  <= CODE_RING_FULL;
    end else if (ctl.loadReq) begin
      recParam <= evParam;
      recLen   <= evLen;
      recType  <= evType;
      recCode  <= evCode;
    end
  end

endmodule

// File: rtl/evring_producer.sv
module evring_producer
  import evring_pkg::*;
#(
  parameter  int ADDR_W    = 64,
  parameter  int SEGS      = 4,
  parameter  int SIZE_W    = 16,
  localparam int SEG_IDX_W = (SEGS > 1) ? $clog2(SEGS) : 1
)(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        ringEnable,
  input  logic                        evValid,
  output logic                        evReady,
  input  logic [5:0]                  evType,
  input  logic [7:0]                  evCode,
  input  logic [63:0]                 evParam,
  input  logic [31:0]                 evLen,
  input  logic [SEGS-1:0][ADDR_W-1:0] segBase,
  input  logic [SEGS-1:0][SIZE_W-1:0] segSize,
  input  logic [SEG_IDX_W:0]          segCount,
  input  logic [ADDR_W-1:0]           deqPtr,
  output logic                        wrValid,
  output logic [ADDR_W-1:0]           wrAddr,
  output logic [31:0]                 wrData,
  output logic [ADDR_W-1:0]           enqAddr,
  output logic [SEG_IDX_W-1:0]        enqSeg,
  output logic                        enqCycle,
  output logic                        evPosted
);

  ctrlStrobes_t ctl;
  logic         ringFull;
  logic         stalled;

  evring_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ringEnable (ringEnable),
    .evValid    (evValid),
    .ringFull   (ringFull),
    .stalled    (stalled),
    .evReady    (evReady),
    .evPosted   (evPosted),
    .ctl        (ctl)
  );

  evring_datapath #(
    .ADDR_W    (ADDR_W),
    .SEGS      (SEGS),
    .SIZE_W    (SIZE_W),
    .SEG_IDX_W (SEG_IDX_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .evType   (evType),
    .evCode   (evCode),
    .evParam  (evParam),
    .evLen    (evLen),
    .segBase  (segBase),
    .segSize  (segSize),
    .segCount (segCount),
    .deqPtr   (deqPtr),
    .ringFull (ringFull),
    .stalled  (stalled),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .enqAddr  (enqAddr),
    .enqSeg   (enqSeg),
    .enqCycle (enqCycle)
  );

endmodule

// File: rtl/evring_producer_checker.sv
module evring_producer_checker #(
  parameter int ADDR_W    = 64,
  parameter int SEG_IDX_W = 2
)(
  input logic                 clk,
  input logic                 rstN,
  input logic                 ringEnable,
  input logic                 evValid,
  input logic                 evReady,
  input logic                 wrValid,
  input logic [ADDR_W-1:0]    wrAddr,
  input logic [31:0]          wrData,
  input logic                 enqCycle,
  input logic [SEG_IDX_W-1:0] enqSeg,
  input logic                 evPosted
);

  logic unusedAddrHi;
  logic unusedDataHi;
  logic flagBeat;

  assign unusedAddrHi = ^{wrAddr[ADDR_W-1:4], wrAddr[1:0]};
  assign unusedDataHi = ^wrData[31:1];
  assign flagBeat     = wrValid && (wrAddr[3:2] == 2'd3);

  // R4: no handshake while a record is on the port
  assert_ready_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    evReady |-> !wrValid);

  // R4: a handshake starts the write beats on the next cycle
  assert_accept_write_R4: assert property (@(posedge clk) disable iff (!rstN || !ringEnable)
    (evValid && evReady) |=> wrValid);

  // R2: beats of one record are back to back until the flags word
  assert_beats_R2: assert property (@(posedge clk) disable iff (!rstN || !ringEnable)
    (wrValid && !flagBeat) |=> wrValid);

  // R3: flags word carries the producer cycle state in bit 0
  assert_flag_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    flagBeat |-> (wrData[0] == enqCycle));

  // R5: posted strobe follows a flags-word beat
  assert_posted_R5: assert property (@(posedge clk) disable iff (!rstN)
    evPosted |-> $past(flagBeat));

  // R8: cycle state only changes on the wrap back to segment 0
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ringEnable && $past(ringEnable) && (enqCycle != $past(enqCycle))) |-> (enqSeg == '0));

endmodule

bind evring_producer evring_producer_checker #(
  .ADDR_W    (ADDR_W),
  .SEG_IDX_W (SEG_IDX_W)
) u_checker (.*);

// File: tb/evring_producer_bench.sv
module evring_producer_bench;

  localparam int SEGS = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ringEnable = 1'b0;
  logic              evValid = 1'b0;
  logic              evReady;
  logic [5:0]        evType = 6'd32;
  logic [7:0]        evCode = 8'd1;
  logic [63:0]       evParam = 64'h0;
  logic [31:0]       evLen = 32'h0;
  logic [SEGS-1:0][63:0] segBase;
  logic [SEGS-1:0][15:0] segSize;
  logic [2:0]        segCount = 3'd3;
  logic [63:0]       deqPtr = 64'h100B;
  logic              wrValid;
  logic [63:0]       wrAddr;
  logic [31:0]       wrData;
  logic [63:0]       enqAddr;
  logic [1:0]        enqSeg;
  logic              enqCycle;
  logic              evPosted;

  int checks = 0;
  int errors = 0;
  int postedCount = 0;

  always #2 clk = ~clk;

  evring_producer u_evring_producer (
    .clk(clk), .rstN(rstN), .ringEnable(ringEnable), .evValid(evValid), .evReady(evReady),
    .evType(evType), .evCode(evCode), .evParam(evParam), .evLen(evLen),
    .segBase(segBase), .segSize(segSize), .segCount(segCount), .deqPtr(deqPtr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .enqAddr(enqAddr),
    .enqSeg(enqSeg), .enqCycle(enqCycle), .evPosted(evPosted)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mBeat = 0;
  bit          mPost = 0;
  int          mSeg = 0;
  int          mOff = 0;
  bit          mCyc = 1;
  bit          mStalled = 0;
  logic [59:0] mStallDeq = '0;
  logic [63:0] mParam = '0;
  logic [31:0] mLen = '0;
  logic [5:0]  mType = '0;
  logic [7:0]  mCode = '0;
  bit          mAccepted = 0;

  function automatic logic [63:0] slotAddr(input int s, input int o);
    return segBase[s] + 64'(o) * 64'd16;
  endfunction

  always @(negedge clk) begin
    logic [63:0] eAddr, nAddr, eData;
    bit eFull, eReady, lastO;
    int nSeg, nOff;
    mAccepted = 0;
    if (!rstN) begin
      mBeat = 0; mPost = 0; mSeg = 0; mOff = 0; mCyc = 1; mStalled = 0;
    end else begin
      if (evPosted) postedCount++;
      lastO = (mOff == int'(segSize[mSeg]) - 1);
      nSeg  = lastO ? ((mSeg == int'(segCount) - 1) ? 0 : mSeg + 1) : mSeg;
      nOff  = lastO ? 0 : mOff + 1;
      eAddr = slotAddr(mSeg, mOff);
      nAddr = slotAddr(nSeg, nOff);
      eFull = (nAddr[63:4] == deqPtr[63:4]);          // R11: low bits ignored
      eReady = ringEnable && (mBeat == 0) && !mStalled && !eFull;
      // per-cycle comparisons
      chk("R4 evReady", 64'(evReady), 64'(eReady));
      chk("R2 wrValid", 64'(wrValid), 64'(ringEnable && mBeat != 0));
      chk("R5 evPosted", 64'(evPosted), 64'(mPost));
      chk("R6 enqAddr", enqAddr, eAddr);
      chk("R8 enqCycle", 64'(enqCycle), 64'(mCyc));
      if (ringEnable && mBeat != 0) begin
        case (mBeat)
          1: eData = 64'(mParam[31:0]);
          2: eData = 64'(mParam[63:32]);
          3: eData = 64'(mLen);
          default: eData = 64'({mCode, 8'h00, mType, 9'h000, mCyc});
        endcase
        chk("R2 wrAddr", wrAddr, eAddr + 64'((mBeat - 1) * 4));
        chk(mBeat == 4 ? "R3 flags word" : "R2 wrData", 64'(wrData), eData);
      end
      // step to next cycle
      if (!ringEnable) begin
        mBeat = 0; mPost = 0; mSeg = 0; mOff = 0; mCyc = 1; mStalled = 0;
      end else begin
        bit wasStalled;
        wasStalled = mStalled;
        mPost = (mBeat == 4);
        if (mBeat == 4) begin
          if (lastO && mSeg == int'(segCount) - 1) mCyc = ~mCyc;
          mSeg = nSeg; mOff = nOff; mBeat = 0;
        end else if (mBeat != 0) begin
          mBeat++;
        end else if (!mStalled && evValid) begin
          if (eFull) begin
            mParam = '0; mLen = '0; mType = 6'd37; mCode = 8'd21;
            mStalled = 1; mStallDeq = deqPtr[63:4];
          end else begin
            mParam = evParam; mLen = evLen; mType = evType; mCode = evCode;
            mAccepted = 1;
          end
          mBeat = 1;
        end
        if (wasStalled && deqPtr[63:4] != mStallDeq) mStalled = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    #1;
    if (mAccepted) begin
      evParam <= evParam + 64'h0000_0001_0000_0003;
      evLen   <= evLen + 32'd7;
      evType  <= (evType == 6'd34) ? 6'd32 : evType + 6'd1;
      evCode  <= evCode + 8'd1;
    end
  end

  initial begin
    segBase[0] = 64'h1000; segBase[1] = 64'h2000;
    segBase[2] = 64'h3000; segBase[3] = 64'h4000;
    segSize[0] = 16'd4; segSize[1] = 16'd2;
    segSize[2] = 16'd3; segSize[3] = 16'd5;
    evParam = 64'h1111_2222_3333_4444;
    evLen   = 32'h0000_0100;
    step(5);
    rstN = 1'b1;
    step(2);
    // R1: reset / disabled state
    chk("R1 enqAddr", enqAddr, 64'h1000);
    chk("R1 enqCycle", 64'(enqCycle), 64'd1);
    chk("R1 evReady", 64'(evReady), 64'd0);
    chk("R1 wrValid", 64'(wrValid), 64'd0);

    // Fill the ring: 8 events (R6, R7), then a ring-full record (R9, R11)
    ringEnable = 1'b1;
    evValid    = 1'b1;
    step(60);
    chk("R9 posted count at full", 64'(postedCount), 64'd9);
    chk("R8 enqAddr after wrap", enqAddr, 64'h1000);
    chk("R8 enqCycle after wrap", 64'(enqCycle), 64'd0);
    chk("R10 stalled evReady", 64'(evReady), 64'd0);

    // R10: software consumes two records, held request goes in, ring fills again
    deqPtr = 64'h1025;
    step(30);
    chk("R10 posted count after release", 64'(postedCount), 64'd11);
    chk("R10 enqAddr after second full", enqAddr, 64'h1020);

    // R11: changing only hint/busy bits does not release the stall
    deqPtr = 64'h1023;
    step(12);
    chk("R11 no release on low bits", 64'(postedCount), 64'd11);
    chk("R11 evReady held low", 64'(evReady), 64'd0);

    // Release with no request pending
    evValid = 1'b0;
    deqPtr  = 64'h3010;
    step(10);
    chk("R10 no post without request", 64'(postedCount), 64'd11);
    chk("R6 enqAddr unchanged", enqAddr, 64'h1020);

    // R12: disabling returns to the start position
    ringEnable = 1'b0;
    step(3);
    chk("R12 enqAddr", enqAddr, 64'h1000);
    chk("R12 enqCycle", 64'(enqCycle), 64'd1);
    chk("R12 enqSeg", 64'(enqSeg), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule